// File: doc/BRIEF.md
# Single-Precision to 4-bit Float Rounding Quantizer

This block takes one already-scaled single-precision value per cycle and turns it into a 4-bit float code with one sign bit, two exponent bits and one mantissa bit. The code grid has eight magnitudes, and the distance between neighbouring magnitudes doubles with each power of two. The block first finds which grid interval the input magnitude falls in. It then picks the lower or the upper end of that interval using the selected rounding mode. Magnitudes too large for the grid are clamped to the largest code.

Two rounding modes are available. Nearest rounding sends ties to the code whose mantissa bit is zero. Stochastic rounding rounds up with a probability equal to how far the input lies across its gap, which keeps the error zero-mean on average. The random value comes from an internal linear feedback shift register, and software can reseed it through a load strobe. The register has three transitions: load (reseed), step (one conversion in stochastic mode) and hold (all other cycles).

Top module: `fp4q_quantizer`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid` is 0 and `out_code` is 4'h0.
- R2: `out_valid` is high exactly one cycle after `in_valid` was high. In cycles after `in_valid` was low, `out_code` keeps its previous value.
- R3: The code layout is bit 3 for the sign (1 = negative) and bits 2:0 for the magnitude index 0..7. The indices stand for 0, 0.5, 1, 1.5, 2, 3, 4 and 6. An input equal to one of these magnitudes gives exactly that index in both modes.
- R4: With `rnd_mode`=0 (nearest), an input between two grid points gives the closer one. An exact midpoint gives the index with bit 0 clear, so 2.5 gives 2, 5 gives 4 and 1.75 gives 2. Any magnitude above 0.25 and below 0.75 gives 0.5.
- R5: Finite magnitudes of 6 or more, and infinities, give index 7 with the input's sign.
- R6: Any NaN input gives 4'b0111.
- R7: Inputs whose exponent field is zero (zeros and subnormals) give index 0 with the input's sign. A negative input that rounds to zero gives 4'b1000.
- R8: With `rnd_mode`=1 (stochastic), write the distance across the gap as a fraction and take its top 16 bits as F. The code is the upper grid point when the current register value is less than F, and the lower grid point otherwise.
- R9: The random register moves to `{s[14:0], s[15]^s[13]^s[12]^s[10]}` on each cycle with `in_valid`=1, `rnd_mode`=1 and `seed_load`=0. In every other cycle without a load it holds its value.
- R10: When `seed_load`=1, the register takes `seed_val` at the next edge. A zero seed, and reset, set it to 16'hACE1 instead. A load wins over a step, and a conversion in the load cycle still uses the old value.
- R11: Over 256 stochastic conversions of an input at the exact middle of a gap, between 96 and 160 of them round up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value present this cycle |
| in_data | input | 32 | Single-precision input value |
| rnd_mode | input | 1 | 0 = nearest-even, 1 = stochastic |
| seed_load | input | 1 | Reseed the random register |
| seed_val | input | 16 | New random register value |
| out_valid | output | 1 | Code present this cycle |
| out_code | output | 4 | Sign and magnitude index |

## Verification
Each code comes out one register stage after its input: an input accepted at edge n has its code on `out_code` and `out_valid` from edge n onward. The bench drives inputs on falling edges and compares the outputs on the next falling edge. A seed load affects only conversions accepted after the edge that loads it. For that reason the bench's own model of the random register is updated after each edge, never before it. All stochastic results are predicted one by one from that model.

// File: rtl/fp4q_pkg.sv
package fp4q_pkg;
    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int BIAS   = 127;
    localparam int CODE_W = 4;
    localparam int MAG_W  = CODE_W - 1;
    localparam int SIG_W  = MAN_W + 1;
    localparam int FRAC_W = 2 * SIG_W;
    localparam int FIX_W  = FRAC_W + 2;

    typedef enum logic [1:0] {
        REG_FINE   = 2'd0,
        REG_MID    = 2'd1,
        REG_COARSE = 2'd2
    } region_e;

    typedef enum logic {
        RM_NEAREST = 1'b0,
        RM_STOCH   = 1'b1
    } rmode_e;
endpackage

// File: rtl/fp4q_lfsr.sv
module fp4q_lfsr #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  TAPS = 16'hB400,
    parameter logic [W-1:0]  INIT = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] state
);
    logic         fb;
    logic [W-1:0] seed_eff;

    always_comb begin
        fb       = ^(state & TAPS);
        seed_eff = (load_val == '0) ? INIT : load_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= INIT;
        else if (load)
            state <= seed_eff;
        else if (step)
            state <= {state[W-2:0], fb};
    end
endmodule

// File: rtl/fp4q_classify.sv
module fp4q_classify
    import fp4q_pkg::*;
(
    input  logic [FP_W-1:0]   fp,
    output logic              sign,
    output logic              is_nan,
    output logic              is_sat,
    output logic [MAG_W-1:0]  lo_mag,
    output logic [FRAC_W-1:0] frac
);
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
    logic [SIG_W-1:0] sig;
    logic [EXP_W-1:0] sh_amt;
    logic [FIX_W-1:0] fixq;
    logic [1:0]       qint;
    region_e          region;
    logic [MAG_W-1:0] base;

    always_comb begin
        sign   = fp[FP_W-1];
        ex     = fp[FP_W-2 -: EXP_W];
        man    = fp[MAN_W-1:0];
        is_nan = (ex == '1) && (man != '0);
        is_sat = !is_nan && ((ex >= EXP_W'(BIAS + 3)) ||
                 ((ex == EXP_W'(BIAS + 2)) && man[MAN_W-1]));
        sig    = (ex == '0) ? '0 : {1'b1, man};
        sh_amt = (ex >= EXP_W'(BIAS)) ? '0 : EXP_W'(BIAS) - ex;
        fixq   = {sig, 2'b00, {SIG_W{1'b0}}} >> sh_amt;
        qint   = fixq[FIX_W-1 -: 2];
        frac   = fixq[FRAC_W-1:0];

        if (ex <= EXP_W'(BIAS))
            region = REG_FINE;
        else if (ex == EXP_W'(BIAS + 1))
            region = REG_MID;
        else
            region = REG_COARSE;

        unique case (region)
            REG_FINE:   base = MAG_W'(0);
            REG_MID:    base = MAG_W'(2);
            REG_COARSE: base = MAG_W'(4);
            default:    base = MAG_W'(0);
        endcase
        lo_mag = base + MAG_W'(qint);
    end
endmodule

// File: rtl/fp4q_round.sv
module fp4q_round
    import fp4q_pkg::*;
#(
    parameter int RND_W = 16
) (
    input  logic [MAG_W-1:0]  lo_mag,
    input  logic [FRAC_W-1:0] frac,
    input  rmode_e            mode,
    input  logic [RND_W-1:0]  rnd,
    output logic [MAG_W-1:0]  mag
);
    localparam logic [FRAC_W-1:0] HALF = {1'b1, {(FRAC_W-1){1'b0}}};
    logic up;

    always_comb begin
        unique case (mode)
            RM_NEAREST: up = (frac > HALF) || ((frac == HALF) && lo_mag[0]);
            RM_STOCH:   up = rnd < frac[FRAC_W-1 -: RND_W];
            default:    up = 1'b0;
        endcase
        mag = lo_mag + MAG_W'(up);
    end
endmodule

// File: rtl/fp4q_quantizer.sv
module fp4q_quantizer
    import fp4q_pkg::*;
#(
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_INIT = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    input  logic              rnd_mode,
    input  logic              seed_load,
    input  logic [LFSR_W-1:0] seed_val,
    output logic              out_valid,
    output logic [3:0]        out_code
);
    logic              c_sign;
    logic              c_nan;
    logic              c_sat;
    logic [MAG_W-1:0]  c_lo;
    logic [FRAC_W-1:0] c_frac;
    logic [MAG_W-1:0]  r_mag;
    logic [LFSR_W-1:0] rnd_state;
    logic              rnd_step;
    rmode_e            mode;
    logic [CODE_W-1:0] code_next;

    assign mode     = rmode_e'(rnd_mode);
    assign rnd_step = in_valid && (mode == RM_STOCH) && !seed_load;

    fp4q_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .INIT(LFSR_INIT)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seed_load),
        .load_val (seed_val),
        .step     (rnd_step),
        .state    (rnd_state)
    );

    fp4q_classify u_cls (
        .fp     (in_data),
        .sign   (c_sign),
        .is_nan (c_nan),
        .is_sat (c_sat),
        .lo_mag (c_lo),
        .frac   (c_frac)
    );

    fp4q_round #(.RND_W(LFSR_W)) u_rnd (
        .lo_mag (c_lo),
        .frac   (c_frac),
        .mode   (mode),
        .rnd    (rnd_state),
        .mag    (r_mag)
    );

    always_comb begin
        if (c_nan)
            code_next = {1'b0, {MAG_W{1'b1}}};
        else if (c_sat)
            code_next = {c_sign, {MAG_W{1'b1}}};
        else
            code_next = {c_sign, r_mag};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_code <= code_next;
        end
    end
endmodule

// File: rtl/fp4q_checker.sv
module fp4q_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        seed_load,
    input logic [15:0] seed_val,
    input logic        out_valid,
    input logic [3:0]  out_code,
    input logic [15:0] lfsr_state
);
    logic in_nan;
    logic in_inf;
    logic in_zexp;

    assign in_nan  = (in_data[30:23] == 8'hFF) && (in_data[22:0] != '0);
    assign in_inf  = (in_data[30:23] == 8'hFF) && (in_data[22:0] == '0);
    assign in_zexp = (in_data[30:23] == 8'h00);

    a_r2_valid_up: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_down: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code));
    a_r5_inf_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_inf) |=> (out_code == {$past(in_data[31]), 3'b111}));
    a_r6_nan_code: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_nan) |=> (out_code == 4'b0111));
    a_r7_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_zexp) |=> (out_code == {$past(in_data[31]), 3'b000}));
    a_r9_hold_rnd: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !seed_load) |=> $stable(lfsr_state));
    a_r10_seed_take: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_val != 16'h0) |=> (lfsr_state == $past(seed_val)));
endmodule

bind fp4q_quantizer fp4q_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .seed_load  (seed_load),
    .seed_val   (seed_val),
    .out_valid  (out_valid),
    .out_code   (out_code),
    .lfsr_state (rnd_state)
);

// File: tb/tb_fp4q_quantizer.sv
module tb_fp4q_quantizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        rnd_mode = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_val = '0;
    logic        out_valid;
    logic [3:0]  out_code;

    int total = 0;
    int bad = 0;
    logic [15:0] m_lfsr = 16'hACE1;

    always #5 clk = ~clk;

    fp4q_quantizer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .rnd_mode(rnd_mode), .seed_load(seed_load), .seed_val(seed_val),
        .out_valid(out_valid), .out_code(out_code)
    );

    function automatic real gridv(int i);
        case (i)
            0: return 0.0;  1: return 0.5;  2: return 1.0;  3: return 1.5;
            4: return 2.0;  5: return 3.0;  6: return 4.0;  default: return 6.0;
        endcase
    endfunction

    function automatic logic [3:0] model(logic [31:0] x, logic md, logic [15:0] r);
        logic [7:0]  e;
        logic [63:0] dbits;
        real m, f;
        int lo, f16;
        logic up;
        e = x[30:23];
        if (e == 8'hFF && x[22:0] != 0) return 4'b0111;
        if (e == 8'hFF) return {x[31], 3'b111};
        if (e == 8'h00) return {x[31], 3'b000};
        dbits = {1'b0, 11'(int'(e) - 127 + 1023), x[22:0], 29'd0};
        m = $bitstoreal(dbits);
        if (m >= 6.0) return {x[31], 3'b111};
        lo = 0;
        for (int i = 1; i < 7; i++) if (m >= gridv(i)) lo = i;
        f = (m - gridv(lo)) / (gridv(lo + 1) - gridv(lo));
        if (md) begin
            f16 = $rtoi(f * 65536.0);
            up = (int'(r) < f16);
        end else
            up = (f > 0.5) || (f == 0.5 && (lo % 2 == 1));
        return {x[31], 3'(lo + int'(up))};
    endfunction

    function automatic logic [15:0] adv(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One conversion: drive at a falling edge, compare at the next one.
    task automatic conv(string req, logic [31:0] x, logic md);
        logic [3:0] exp;
        exp = model(x, md, m_lfsr);
        in_valid = 1'b1; in_data = x; rnd_mode = md;
        @(negedge clk);
        if (md) m_lfsr = adv(m_lfsr);
        chk(req, out_code, exp);
        chk({req, " valid"}, {3'b0, out_valid}, 4'h1);
        in_valid = 1'b0;
    endtask

    task automatic do_seed(logic [15:0] s);
        seed_load = 1'b1; seed_val = s;
        @(negedge clk);
        seed_load = 1'b0;
        m_lfsr = (s == 16'h0) ? 16'hACE1 : s;
    endtask

    task automatic t_reset;
        chk("R1 reset code", out_code, 4'h0);
        chk("R1 reset valid", {3'b0, out_valid}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {3'b0, out_valid}, 4'h0);
    endtask

    task automatic t_grid;
        logic [31:0] pts [8] = '{32'h0, 32'h3F000000, 32'h3F800000, 32'h3FC00000,
                                 32'h40000000, 32'h40400000, 32'h40800000, 32'h40C00000};
        foreach (pts[i]) begin
            conv("R3 exact nearest", pts[i], 1'b0);
            chk("R3 exact index", out_code, 4'(i));
            conv("R3 exact stochastic", pts[i] | 32'h80000000, 1'b1);
        end
    endtask

    task automatic t_nearest;
        conv("R4 tie 2.5", 32'h40200000, 1'b0);  chk("R4 2.5->2", out_code, 4'h4);
        conv("R4 tie 5.0", 32'h40A00000, 1'b0);  chk("R4 5->4", out_code, 4'h6);
        conv("R4 tie 1.75", 32'h3FE00000, 1'b0); chk("R4 1.75->2", out_code, 4'h4);
        conv("R4 tie 0.25", 32'h3E800000, 1'b0); chk("R4 0.25->0", out_code, 4'h0);
        conv("R4 0.3", 32'h3E99999A, 1'b0);      chk("R4 0.3->0.5", out_code, 4'h1);
        conv("R4 3.5", 32'h40600000, 1'b0);
        conv("R4 -2.6", 32'hC0266666, 1'b0);
        conv("R4 2.75", 32'h40300000, 1'b0);
        conv("R4 4.5", 32'h40900000, 1'b0);
        conv("R4 5.5", 32'h40B00000, 1'b0);
        conv("R4 below 6", 32'h40BFFFFF, 1'b0);
    endtask

    task automatic t_sat;
        conv("R5 100", 32'h42C80000, 1'b0);  chk("R5 100 code", out_code, 4'h7);
        conv("R5 -6", 32'hC0C00000, 1'b1);   chk("R5 -6 code", out_code, 4'hF);
        conv("R5 -inf", 32'hFF800000, 1'b0); chk("R5 -inf code", out_code, 4'hF);
        conv("R5 +inf", 32'h7F800000, 1'b1);
    endtask

    task automatic t_nan;
        conv("R6 qnan", 32'h7FC00000, 1'b0); chk("R6 qnan code", out_code, 4'h7);
        conv("R6 neg nan", 32'hFF800001, 1'b1); chk("R6 neg nan code", out_code, 4'h7);
    endtask

    task automatic t_zero;
        conv("R7 -0.1", 32'hBDCCCCCD, 1'b0);    chk("R7 -0.1 code", out_code, 4'h8);
        conv("R7 subnormal", 32'h000116C2, 1'b1);
        conv("R7 -0", 32'h80000000, 1'b0);      chk("R7 -0 code", out_code, 4'h8);
    endtask

    task automatic t_stoch;
        do_seed(16'h5A5A);
        for (int i = 0; i < 24; i++) begin
            conv("R8 stochastic 0.75", 32'h3F400000, 1'b1);
            conv("R8 stochastic -2.6", 32'hC0266666, 1'b1);
            conv("R8 stochastic 5.9", 32'h40BCCCCD, 1'b1);
        end
    endtask

    task automatic t_idle;
        // nearest conversions and idle cycles must leave the register as is
        do_seed(16'h1357);
        conv("R9 nearest no step", 32'h3FA00000, 1'b0);
        conv("R9 nearest no step", 32'h40200000, 1'b0);
        repeat (5) @(negedge clk);
        for (int i = 0; i < 16; i++) conv("R9 sequence", 32'h3F400000, 1'b1);
    endtask

    task automatic t_seed;
        logic [3:0] exp;
        do_seed(16'h0000);
        for (int i = 0; i < 16; i++) conv("R10 zero seed", 32'h3FA00000, 1'b1);
        // conversion in the load cycle uses the old value
        exp = model(32'h3F400000, 1'b1, m_lfsr);
        in_valid = 1'b1; in_data = 32'h3F400000; rnd_mode = 1'b1;
        seed_load = 1'b1; seed_val = 16'hF00D;
        @(negedge clk);
        in_valid = 1'b0; seed_load = 1'b0;
        m_lfsr = 16'hF00D;
        chk("R10 load cycle", out_code, exp);
        for (int i = 0; i < 16; i++) conv("R10 after load", 32'h3F400000, 1'b1);
    endtask

    task automatic t_mean;
        int ups = 0;
        do_seed(16'h1234);
        for (int i = 0; i < 256; i++) begin
            conv("R11 sample", 32'h3FA00000, 1'b1);
            if (out_code == 4'h3) ups++;
        end
        chk("R11 balance", 4'((ups >= 96 && ups <= 160) ? 1 : 0), 4'h1);
        if (!(ups >= 96 && ups <= 160)) $display("R11 up count %0d", ups);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_grid;
        t_nearest;
        t_sat;
        t_nan;
        t_zero;
        t_stoch;
        t_idle;
        t_seed;
        t_mean;
        @(negedge clk);
        chk("R2 valid drops", {3'b0, out_valid}, 4'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule